// File: doc/BRIEF.md
# Stereo Soft Mute with Zero-Run Automute

This block sits on a stereo PCM sample path and scales both channels by a common gain that moves gradually between unity and zero, so that muting fades the signal instead of cutting it. One sample period is marked by a strobe on `smp_valid`. On each strobe the gain moves one step towards its target, which means a full fade takes about a thousand sample periods, roughly 21 ms at 48 kHz.

The mute request comes from a control pin that can be driven low, driven high or left floating. It is modelled as a level plus a flag that says whether the pin is driven. When the pin is driven low the path always plays, and when it is driven high the path always mutes. When the pin floats, a zero-run detector decides. The detector counts consecutive stereo pairs that are zero on both channels and sets an automute latch after a long run. While the pin floats, that latch controls the fade and is also shown on an indication output, so that an external mute circuit can use it.

Top module: `stereo_soft_mute`

## Requirements
- R1: After reset the gain is 1024 (unity), both output samples are 0, `out_valid` is 0 and `auto_mute_out` is 0.
- R2: One clock after a strobe, `out_valid` is 1 and each output equals the two's-complement input sample times the gain held at the strobe, arithmetically shifted right by 10 bits (rounding towards minus infinity). The lower 24 bits of that result are presented.
- R3: While the pin is driven high (`mute_driven`=1, `mute_level`=1), each strobe lowers the gain by 1 until it reaches 0. After that the outputs are 0.
- R4: While the pin is driven low (`mute_driven`=1, `mute_level`=0), each strobe raises the gain by 1 until it reaches 1024. A set automute latch has no effect, and `auto_mute_out` stays 0.
- R5: The automute latch sets on the 1024th consecutive strobe at which both channels are zero. It does not set after 1023.
- R6: A strobe with a non-zero sample on either channel clears the latch and restarts the zero-run count from 0.
- R7: While the pin floats (`mute_driven`=0), the fade direction follows the latch (latch 1 mutes, latch 0 unmutes), and `auto_mute_out` equals the latch.
- R8: If the mute request reverses partway through a fade, the fade turns around from the gain it has reached, with no jump.
- R9: Between strobes the gain, the latch, the zero-run count and the output samples hold their values, and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| smp_valid | input | 1 | Strobe marking one stereo sample period |
| smp_left | input | 24 | Left channel input sample, two's complement |
| smp_right | input | 24 | Right channel input sample, two's complement |
| mute_level | input | 1 | Level on the mute control pin when it is driven |
| mute_driven | input | 1 | 1 when the mute control pin is driven, 0 when it floats |
| out_valid | output | 1 | One-clock strobe for the scaled samples |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| gain_level | output | 11 | Current gain, 0 to 1024 |
| auto_mute_out | output | 1 | Automute latch, shown while the pin floats, otherwise 0 |

## Verification
The assertions assume that `mute_level` only matters while `mute_driven` is 1, and that the samples are only looked at on strobe cycles. They also assume that the mute inputs are steady across each clock edge. The stimulus changes every input only on the falling clock edge. It keeps the level at a defined value even while the pin floats, and it mixes back-to-back strobes with idle cycles. The zero runs are sized to stop exactly one pair short of the threshold and to cross it, so that both sides of the latch boundary are exercised.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic [1:0] {
    SRC_PLAY  = 2'd0,
    SRC_MUTE  = 2'd1,
    SRC_AUTO  = 2'd2
  } mute_src_e;

  function automatic mute_src_e classify_pin(input logic driven, input logic level);
    if (!driven)    return SRC_AUTO;
    else if (level) return SRC_MUTE;
    else            return SRC_PLAY;
  endfunction

  function automatic logic resolve_mute(input mute_src_e src, input logic latch);
    case (src)
      SRC_MUTE: return 1'b1;
      SRC_AUTO: return latch;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/zero_run_detect.sv
module zero_run_detect #(
  parameter int DATA_W  = 24,
  parameter int RUN_LEN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              latch_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_FULL = CW'(RUN_LEN);
  localparam logic [CW-1:0] RUN_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q, run_d;
  logic          latch_q, latch_d;
  logic          pair_zero;

  always_comb begin
    pair_zero = (left_i == '0) && (right_i == '0);
    run_d     = run_q;
    latch_d   = latch_q;
    if (en) begin
      if (!pair_zero) begin
        run_d   = '0;
        latch_d = 1'b0;
      end else if (run_q != RUN_FULL) begin
        run_d = run_q + 1'b1;
        if (run_q == RUN_LAST) latch_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      latch_q <= latch_d;
    end
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/gain_ramp.sv
module gain_ramp #(
  parameter int GAIN_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            mute_i,
  output logic [GAIN_W:0] gain_o
);
  localparam logic [GAIN_W:0] UNITY = (GAIN_W+1)'(1) << GAIN_W;

  logic [GAIN_W:0] gain_q, gain_d;

  always_comb begin
    gain_d = gain_q;
    if (en) begin
      if (mute_i) begin
        if (gain_q != '0) gain_d = gain_q - 1'b1;
      end else begin
        if (gain_q != UNITY) gain_d = gain_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain_q <= UNITY;
    else        gain_q <= gain_d;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/sample_scale.sv
module sample_scale #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  input  logic [GAIN_W:0]   gain_i,
  output logic [DATA_W-1:0] dout
);
  localparam int PW = DATA_W + GAIN_W + 2;

  logic signed [PW-1:0]     prod;
  logic signed [DATA_W-1:0] scaled;
  logic        [DATA_W-1:0] dout_q, dout_d;

  always_comb begin
    prod   = PW'($signed(din)) * PW'($signed({1'b0, gain_i}));
    scaled = DATA_W'(prod >>> GAIN_W);
    dout_d = en ? scaled : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/stereo_soft_mute.sv
module stereo_soft_mute #(
  parameter int DATA_W  = 24,
  parameter int GAIN_W  = 10,
  parameter int RUN_LEN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_left,
  input  logic [DATA_W-1:0] smp_right,
  input  logic              mute_level,
  input  logic              mute_driven,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right,
  output logic [GAIN_W:0]   gain_level,
  output logic              auto_mute_out
);
  import smute_pkg::*;

  localparam int NCH = 2;

  logic                    auto_latch;
  logic                    eff_mute;
  mute_src_e               pin_src;
  logic [GAIN_W:0]         gain_now;
  logic [NCH-1:0][DATA_W-1:0] ch_in, ch_out;
  logic                    vld_q, vld_d;

  zero_run_detect #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_zero (
    .clk(clk), .rst_n(rst_n), .en(smp_valid),
    .left_i(smp_left), .right_i(smp_right), .latch_o(auto_latch)
  );

  always_comb begin
    pin_src  = classify_pin(mute_driven, mute_level);
    eff_mute = resolve_mute(pin_src, auto_latch);
  end

  gain_ramp #(.GAIN_W(GAIN_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(smp_valid),
    .mute_i(eff_mute), .gain_o(gain_now)
  );

  assign ch_in[0] = smp_left;
  assign ch_in[1] = smp_right;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    sample_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .clk(clk), .rst_n(rst_n), .en(smp_valid),
      .din(ch_in[c]), .gain_i(gain_now), .dout(ch_out[c])
    );
  end

  always_comb vld_d = smp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid     = vld_q;
  assign out_left      = ch_out[0];
  assign out_right     = ch_out[1];
  assign gain_level    = gain_now;
  assign auto_mute_out = (pin_src == SRC_AUTO) && auto_latch;
endmodule

// File: rtl/stereo_soft_mute_chk.sv
module stereo_soft_mute_chk #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_left,
  input logic [DATA_W-1:0] smp_right,
  input logic              mute_level,
  input logic              mute_driven,
  input logic              out_valid,
  input logic [GAIN_W:0]   gain_level,
  input logic              latch
);
  localparam logic [GAIN_W:0] UNITY = (GAIN_W+1)'(1) << GAIN_W;

  p_gain_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gain_level <= UNITY);

  p_forced_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && mute_driven && mute_level && gain_level != '0
    |=> gain_level == $past(gain_level) - 1'b1);

  p_forced_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && mute_driven && !mute_level && gain_level != UNITY
    |=> gain_level == $past(gain_level) + 1'b1);

  p_nonzero_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (smp_left != '0 || smp_right != '0) |=> !latch);

  p_float_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !mute_driven && latch && gain_level != '0
    |=> gain_level == $past(gain_level) - 1'b1);

  p_strobe_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(gain_level) && !out_valid && $stable(latch));
endmodule

bind stereo_soft_mute stereo_soft_mute_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_left(smp_left),
  .smp_right(smp_right), .mute_level(mute_level), .mute_driven(mute_driven),
  .out_valid(out_valid), .gain_level(gain_level), .latch(auto_latch)
);

// File: tb/stereo_soft_mute_test.sv
`timescale 1ns/1ps
module stereo_soft_mute_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [23:0] smp_left, smp_right;
  logic        mute_level, mute_driven;
  logic        out_valid;
  logic [23:0] out_left, out_right;
  logic [10:0] gain_level;
  logic        auto_mute_out;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural reference state
  int          m_gain  = 1024;
  int          m_run   = 0;
  bit          m_latch = 1'b0;
  logic [23:0] e_left  = '0;
  logic [23:0] e_right = '0;
  bit          e_valid = 1'b0;

  always #2 clk = ~clk;

  stereo_soft_mute uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right),
    .mute_level(mute_level), .mute_driven(mute_driven),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .gain_level(gain_level), .auto_mute_out(auto_mute_out)
  );

  function automatic logic [23:0] ref_scale(input logic [23:0] s, input int g);
    longint p;
    p = longint'($signed(s)) * longint'(g);
    p = p >>> 10;
    return p[23:0];
  endfunction

  function automatic logic [23:0] rnd_nz();
    return 24'($urandom) | 24'h000001;
  endfunction

  task automatic check_all(input string tag, input bit drv);
    bit e_auto;
    e_auto = m_latch && !drv;
    n_tests++;
    if (out_valid !== e_valid || out_left !== e_left || out_right !== e_right ||
        gain_level !== 11'(m_gain) || auto_mute_out !== e_auto) begin
      n_fail++;
      $display("FAIL %s: act v=%0b l=%h r=%h g=%0d a=%0b exp v=%0b l=%h r=%h g=%0d a=%0b",
               tag, out_valid, out_left, out_right, gain_level, auto_mute_out,
               e_valid, e_left, e_right, m_gain, e_auto);
    end
  endtask

  task automatic step(input bit v, input logic [23:0] l, input logic [23:0] r,
                      input bit drv, input bit lvl, input string tag);
    bit mute;
    @(negedge clk);
    smp_valid = v; smp_left = l; smp_right = r;
    mute_driven = drv; mute_level = lvl;
    if (v) begin
      mute    = drv ? lvl : m_latch;
      e_valid = 1'b1;
      e_left  = ref_scale(l, m_gain);
      e_right = ref_scale(r, m_gain);
      if (mute && m_gain > 0)        m_gain--;
      else if (!mute && m_gain < 1024) m_gain++;
      if (l == 0 && r == 0) begin
        if (m_run < 1024) m_run++;
        if (m_run == 1024) m_latch = 1'b1;
      end else begin
        m_run = 0;
        m_latch = 1'b0;
      end
    end else begin
      e_valid = 1'b0;
    end
    @(posedge clk);
    #1;
    check_all(tag, drv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act running exp finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_left = '0; smp_right = '0;
    mute_level = 1'b0; mute_driven = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_all("R1 reset", 1'b1);

    // R2 / R9: normal play, alternating strobes and idle cycles
    for (int i = 0; i < 60; i++) begin
      step(1'b1, 24'($urandom), 24'($urandom), 1'b1, 1'b0, "R2 play");
      if (i % 3 == 0) step(1'b0, 24'($urandom), 24'($urandom), 1'b1, 1'b0, "R9 idle");
    end
    // R3: forced mute fades to zero and stays there
    for (int i = 0; i < 1100; i++) begin
      step(1'b1, rnd_nz(), rnd_nz(), 1'b1, 1'b1, "R3 forced mute");
      if (i % 97 == 0) step(1'b0, rnd_nz(), rnd_nz(), 1'b1, 1'b1, "R9 idle in fade");
    end
    // R8: reversals in mid-fade
    for (int i = 0; i < 300; i++) step(1'b1, rnd_nz(), rnd_nz(), 1'b1, 1'b0, "R8 up");
    for (int i = 0; i < 120; i++) step(1'b1, rnd_nz(), rnd_nz(), 1'b1, 1'b1, "R8 down");
    for (int i = 0; i < 900; i++) step(1'b1, rnd_nz(), rnd_nz(), 1'b1, 1'b0, "R8 up again");
    // R6: 1023 zero pairs then a non-zero one, floating pin, latch must stay clear
    for (int i = 0; i < 1023; i++) step(1'b1, '0, '0, 1'b0, 1'b0, "R6 short run");
    step(1'b1, '0, rnd_nz(), 1'b0, 1'b0, "R6 break run");
    // R5 / R7: full zero run sets latch, floating pin fades down
    for (int i = 0; i < 2150; i++) begin
      step(1'b1, '0, '0, 1'b0, 1'b1, "R5 zero run");
      if (i % 211 == 5) step(1'b0, '0, '0, 1'b0, 1'b1, "R9 idle in run");
    end
    // R6 / R7: a non-zero sample clears the latch, fade back up
    step(1'b1, rnd_nz(), '0, 1'b0, 1'b0, "R6 clear");
    for (int i = 0; i < 200; i++) step(1'b1, rnd_nz(), rnd_nz(), 1'b0, 1'b0, "R7 float play");
    for (int i = 0; i < 900; i++) step(1'b1, '0, '0, 1'b0, 1'b0, "R7 float partial run");
    for (int i = 0; i < 40; i++) step(1'b1, rnd_nz(), rnd_nz(), 1'b0, 1'b0, "R7 float play 2");
    // R4: driven low overrides a set latch
    for (int i = 0; i < 1100; i++) step(1'b1, '0, '0, 1'b1, 1'b0, "R4 override");
    for (int i = 0; i < 60; i++) step(1'b1, '0, '0, 1'b0, 1'b0, "R7 release to float");
    for (int i = 0; i < 30; i++) step(1'b1, '0, '0, 1'b1, 1'b0, "R4 re-drive low");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule